// File: doc/BRIEF.md
# Half-Cycle Alternating SPWM Gate Controller

This block drives the four switches of a single-stage inverter built from two unidirectional converter units whose outputs are joined in anti-parallel. One unit makes the positive half of the output wave and the other makes the negative half. During each half only one unit is connected, through its own selection switch. That unit's main switch is modulated with unipolar sinusoidal PWM: a rectified sine magnitude is compared against a triangular carrier that never goes below zero. Between the two halves a programmable dead interval keeps both selection switches open, so the two output capacitors are never tied together.

The sine magnitude comes from a quarter-wave table that is filled at elaboration. It is read once per carrier period, at the carrier minimum, with mirrored addressing. The duty compare value is the product of that magnitude, the modulation index and the carrier height. The index is clamped so that the peak duty never exceeds 0.78. This keeps each converter unit in discontinuous conduction, where its output follows the duty ratio linearly. With the defaults and a 50 MHz clock, the carrier runs at about 12 kHz and the output period at about 50 Hz.

Top module: `hcpwm_gate_ctrl`

## Requirements
- R1: While reset is high, and afterwards while the enable stays low, all four outputs are low.
- R2: When the enable rises, the positive selection output goes high on the second rising clock edge. The first half-cycle is always the positive one, and it starts at phase index 0.
- R3: Each selection output stays high for exactly 2*QW_DEPTH carrier periods of 2*CAR_HALF clocks each. The positive and negative selection outputs are never high together.
- R4: After every half-cycle both selection outputs are low for max(D,1) clocks, after which the other polarity begins. D is the dead-length input sampled on the last clock of the half; changes to D at any other time do not affect that interval.
- R5: In a positive half, carrier period p (0 to 2*QW_DEPTH-1) at clock position i (0 to 2*CAR_HALF-1) drives the positive modulated output high exactly when tri(i) < C(p). Here tri(i) = i for i < CAR_HALF and 2*CAR_HALF-1-i otherwise. Each period therefore carries one centred pulse of 2*C(p) clocks.
- R6: In a negative half the negative modulated output follows the same rule as R5, using the magnitude of the inverted negative sine half.
- R7: The magnitude for period p is S(j) with j = p for p < QW_DEPTH and j = 2*QW_DEPTH-1-p otherwise. S(j) = floor((2^SIN_W-1)*16a / (5n^2-4a)), where k = 2j+1, n = 4*QW_DEPTH and a = k(n-k).
- R8: C(p) = floor(S(j)*Meff*CAR_HALF / 2^(SIN_W+MOD_W)). Meff = min(M, floor(78*2^MOD_W/100)), and M is the modulation input read at the start of each carrier period. As a result, C(p)/CAR_HALF never exceeds 0.78.
- R9: A modulated output is low whenever its own selection output is low, which covers dead intervals, the other half and the disabled state.
- R10: When the enable drops, all outputs are low from the second clock edge onward. A later enable restarts at the beginning of a positive half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low forces all gates off |
| mod_idx | input | MOD_W | Modulation index, unsigned fraction of 2^MOD_W |
| dead_len | input | DEAD_W | Dead interval length in clocks (0 acts as 1) |
| drv_pos | output | 1 | Modulated switch gate, positive unit |
| drv_neg | output | 1 | Modulated switch gate, negative unit |
| sel_pos | output | 1 | Selection switch gate, positive unit |
| sel_neg | output | 1 | Selection switch gate, negative unit |

## Verification
The bench builds the block with CAR_HALF=8, QW_DEPTH=4, SIN_W=8, MOD_W=8 and DEAD_W=4. With these values a half-cycle is 128 clocks, so every clock of several complete halves of both polarities is compared against pulse patterns computed from the sine and duty formulas. The small sizes bring the clamp boundary (indices below, at and above 199), a zero index, a zero dead length and dead-length changes both before and inside the dead interval into reach. The same run covers a disable in the middle of a half followed by a restart.

// File: rtl/hcpwm_pkg.sv
package hcpwm_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_GAP  = 2'd2
    } phase_e;

    typedef enum logic {
        HALF_POS = 1'b0,
        HALF_NEG = 1'b1
    } half_e;

    typedef struct packed {
        logic sel_pos;
        logic sel_neg;
        logic drv_pos;
        logic drv_neg;
    } gates_t;

    // rational sine approximation of the j-th quarter-wave sample
    function automatic int qsine(input int j, input int qw, input int sw);
        longint k, n, a, num, den;
        k   = 2 * longint'(j) + 1;
        n   = 4 * longint'(qw);
        a   = k * (n - k);
        num = 16 * a * ((longint'(1) <<< sw) - 1);
        den = 5 * n * n - 4 * a;
        return int'(num / den);
    endfunction

    // largest modulation index keeping peak duty at or below 0.78
    function automatic int mod_limit(input int mw);
        return int'((longint'(78) * (longint'(1) <<< mw)) / 100);
    endfunction

endpackage

// File: rtl/hcpwm_qsine_rom.sv
module hcpwm_qsine_rom #(
    parameter int QW = 60,
    parameter int SW = 10,
    parameter int IW = $clog2(2 * QW)
) (
    input  logic [IW-1:0] idx,
    output logic [SW-1:0] mag
);
    localparam int JW = $clog2(QW);
    localparam logic [IW-1:0] QW_I  = IW'(QW);
    localparam logic [IW-1:0] TOP_I = IW'(2 * QW - 1);

    logic [SW-1:0] tbl [QW];

    for (genvar j = 0; j < QW; j++) begin : g_entry
        localparam logic [SW-1:0] VAL = SW'(hcpwm_pkg::qsine(j, QW, SW));
        assign tbl[j] = VAL;
    end

    logic [IW-1:0] mirrored;
    always_comb begin
        mirrored = (idx < QW_I) ? idx : (TOP_I - idx);
        mag      = tbl[mirrored[JW-1:0]];
    end
endmodule

// File: rtl/hcpwm_carrier.sv
module hcpwm_carrier #(
    parameter int H  = 2083,
    parameter int TW = $clog2(2 * H),
    parameter int CW = $clog2(H + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hold,
    output logic [CW-1:0] level,
    output logic          last
);
    localparam logic [TW-1:0] H_T    = TW'(H);
    localparam logic [TW-1:0] LAST_T = TW'(2 * H - 1);

    logic [TW-1:0] pos_q;
    logic [TW-1:0] fold;

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            pos_q <= '0;
        end else if (pos_q == LAST_T) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_q + 1'b1;
        end
    end

    always_comb begin
        fold  = (pos_q < H_T) ? pos_q : (LAST_T - pos_q);
        level = CW'(fold);
        last  = (pos_q == LAST_T);
    end
endmodule

// File: rtl/hcpwm_seq.sv
module hcpwm_seq
    import hcpwm_pkg::*;
#(
    parameter int QW = 60,
    parameter int IW = $clog2(2 * QW),
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          car_last,
    input  logic [DW-1:0] dead_len,
    output phase_e        st,
    output half_e         half,
    output logic          hold,
    output logic          load,
    output logic [IW-1:0] load_idx
);
    localparam logic [IW-1:0] LAST_K = IW'(2 * QW - 1);
    localparam logic [DW-1:0] ONE_D  = DW'(1);

    phase_e        st_q;
    half_e         half_q;
    logic [IW-1:0] k_q;
    logic [DW-1:0] dcnt_q;

    always_comb begin
        load     = 1'b0;
        load_idx = '0;
        unique case (st_q)
            PH_IDLE: load = en;
            PH_RUN: begin
                load     = en && car_last && (k_q != LAST_K);
                load_idx = k_q + 1'b1;
            end
            PH_GAP:  load = en && (dcnt_q == ONE_D);
            default: load = 1'b0;
        endcase
        hold = (st_q != PH_RUN);
        st   = st_q;
        half = half_q;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st_q   <= PH_IDLE;
            half_q <= HALF_POS;
            k_q    <= '0;
            dcnt_q <= '0;
        end else begin
            unique case (st_q)
                PH_IDLE: begin
                    st_q   <= PH_RUN;
                    half_q <= HALF_POS;
                    k_q    <= '0;
                end
                PH_RUN: begin
                    if (car_last) begin
                        if (k_q == LAST_K) begin
                            st_q   <= PH_GAP;
                            dcnt_q <= (dead_len == '0) ? ONE_D : dead_len;
                        end else begin
                            k_q <= k_q + 1'b1;
                        end
                    end
                end
                PH_GAP: begin
                    if (dcnt_q == ONE_D) begin
                        st_q   <= PH_RUN;
                        half_q <= (half_q == HALF_POS) ? HALF_NEG : HALF_POS;
                        k_q    <= '0;
                    end else begin
                        dcnt_q <= dcnt_q - 1'b1;
                    end
                end
                default: st_q <= PH_IDLE;
            endcase
        end
    end

    // R4: the dead counter is never empty while a gap is running
    a_r4_gap_count_live: assert property (@(posedge clk) disable iff (rst)
        (st_q == PH_GAP) |-> (dcnt_q != '0));
endmodule

// File: rtl/hcpwm_drive.sv
module hcpwm_drive
    import hcpwm_pkg::*;
#(
    parameter int H  = 2083,
    parameter int CW = $clog2(H + 1),
    parameter int SW = 10,
    parameter int MW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [SW-1:0] mag,
    input  logic [MW-1:0] mod_idx,
    input  phase_e        st,
    input  half_e         half,
    input  logic [CW-1:0] level,
    output gates_t        gates
);
    localparam int PW = SW + MW + CW;
    localparam logic [MW-1:0] LIM = MW'(hcpwm_pkg::mod_limit(MW));

    logic [MW-1:0] mod_eff;
    logic [PW-1:0] prod;
    logic [CW-1:0] cmp_nxt;
    logic [CW-1:0] cmp_q;
    gates_t        g_q;
    logic          run;

    always_comb begin
        mod_eff = (mod_idx > LIM) ? LIM : mod_idx;
        prod    = PW'(mag) * PW'(mod_eff) * PW'(H);
        cmp_nxt = CW'(prod >> (SW + MW));
        run     = (st == PH_RUN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q <= '0;
            g_q   <= '0;
        end else begin
            if (load) begin
                cmp_q <= cmp_nxt;
            end
            g_q.sel_pos <= run && (half == HALF_POS);
            g_q.sel_neg <= run && (half == HALF_NEG);
            g_q.drv_pos <= run && (half == HALF_POS) && (level < cmp_q);
            g_q.drv_neg <= run && (half == HALF_NEG) && (level < cmp_q);
        end
    end

    assign gates = g_q;

    // R8: latched compare never exceeds 0.78 of the carrier height
    a_r8_duty_cap: assert property (@(posedge clk) disable iff (rst)
        (32'(cmp_q) * 100) <= (78 * H));
endmodule

// File: rtl/hcpwm_gate_ctrl.sv
module hcpwm_gate_ctrl
    import hcpwm_pkg::*;
#(
    parameter int CAR_HALF = 2083,
    parameter int QW_DEPTH = 60,
    parameter int SIN_W    = 10,
    parameter int MOD_W    = 8,
    parameter int DEAD_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [MOD_W-1:0]  mod_idx,
    input  logic [DEAD_W-1:0] dead_len,
    output logic              drv_pos,
    output logic              drv_neg,
    output logic              sel_pos,
    output logic              sel_neg
);
    localparam int IW = $clog2(2 * QW_DEPTH);
    localparam int TW = $clog2(2 * CAR_HALF);
    localparam int CW = $clog2(CAR_HALF + 1);

    phase_e          st;
    half_e           half;
    logic            hold;
    logic            load;
    logic [IW-1:0]   load_idx;
    logic [CW-1:0]   level;
    logic            car_last;
    logic [SIN_W-1:0] mag;
    gates_t          gates;

    hcpwm_seq #(.QW(QW_DEPTH), .IW(IW), .DW(DEAD_W)) i_seq (
        .clk(clk), .rst(rst), .en(en), .car_last(car_last),
        .dead_len(dead_len), .st(st), .half(half), .hold(hold),
        .load(load), .load_idx(load_idx)
    );

    hcpwm_carrier #(.H(CAR_HALF), .TW(TW), .CW(CW)) i_carrier (
        .clk(clk), .rst(rst), .hold(hold), .level(level), .last(car_last)
    );

    hcpwm_qsine_rom #(.QW(QW_DEPTH), .SW(SIN_W), .IW(IW)) i_rom (
        .idx(load_idx), .mag(mag)
    );

    hcpwm_drive #(.H(CAR_HALF), .CW(CW), .SW(SIN_W), .MW(MOD_W)) i_drive (
        .clk(clk), .rst(rst), .load(load), .mag(mag), .mod_idx(mod_idx),
        .st(st), .half(half), .level(level), .gates(gates)
    );

    assign drv_pos = gates.drv_pos;
    assign drv_neg = gates.drv_neg;
    assign sel_pos = gates.sel_pos;
    assign sel_neg = gates.sel_neg;

    // R3: selection switches never close together
    a_r3_sel_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(sel_pos && sel_neg));

    // R4: a selection switch never closes straight after the other opens
    a_r4_gap_before_neg: assert property (@(posedge clk) disable iff (rst)
        $rose(sel_neg) |-> !$past(sel_pos));
    a_r4_gap_before_pos: assert property (@(posedge clk) disable iff (rst)
        $rose(sel_pos) |-> !$past(sel_neg));

    // R10: two clocks of low enable leave every gate open
    a_r10_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
        (!$past(en) && !$past(en, 2)) |-> !(sel_pos || sel_neg || drv_pos || drv_neg));
endmodule

// File: tb/test_hcpwm_gate_ctrl.sv
module test_hcpwm_gate_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int H   = 8;
    localparam int QW  = 4;
    localparam int SW  = 8;
    localparam int MW  = 8;
    localparam int DW  = 4;
    localparam int NHALF = 2 * QW * 2 * H;
    localparam int LIMIT = 199;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic [MW-1:0] mod_idx  = '0;
    logic [DW-1:0] dead_len = '0;
    logic drv_pos, drv_neg, sel_pos, sel_neg;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hcpwm_gate_ctrl #(.CAR_HALF(H), .QW_DEPTH(QW), .SIN_W(SW), .MOD_W(MW), .DEAD_W(DW))
        i_hcpwm_gate_ctrl (
            .clk(clk), .rst(rst), .en(en), .mod_idx(mod_idx), .dead_len(dead_len),
            .drv_pos(drv_pos), .drv_neg(drv_neg), .sel_pos(sel_pos), .sel_neg(sel_neg)
        );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
        end
    endtask

    function automatic int clampm(input int m);
        return (m > LIMIT) ? LIMIT : m;
    endfunction

    // R7/R8 model computed from the stated formulas
    function automatic int exp_cmp(input int p, input int m_eff);
        longint j, k, n, a, s;
        j = (p < QW) ? p : (2 * QW - 1 - p);
        k = 2 * j + 1;
        n = 4 * QW;
        a = k * (n - k);
        s = (16 * a * 255) / (5 * n * n - 4 * a);
        return int'((s * m_eff * H) >>> (SW + MW));
    endfunction

    function automatic int tri_at(input int i);
        return (i < H) ? i : (2 * H - 1 - i);
    endfunction

    task automatic all_low(input string req);
        check({req, " sel_pos"}, int'(sel_pos), 0);
        check({req, " sel_neg"}, int'(sel_neg), 0);
        check({req, " drv_pos"}, int'(drv_pos), 0);
        check({req, " drv_neg"}, int'(drv_neg), 0);
    endtask

    // entered at the sample of position 0 of a half; leaves at next half start
    task automatic run_half(input bit neg, input int m_eff, input int new_mod,
                            input int new_dead, input int gap_dead, input int exp_gap);
        int g;
        for (int n = 0; n < NHALF; n++) begin
            int p = n / (2 * H);
            int i = n % (2 * H);
            int e = (tri_at(i) < exp_cmp(p, m_eff)) ? 1 : 0;
            if (!neg) begin
                check("R3 own selection high", int'(sel_pos), 1);
                check("R3 other selection low", int'(sel_neg), 0);
                check("R5 positive pulse", int'(drv_pos), e);
                check("R9 negative gate idle", int'(drv_neg), 0);
            end else begin
                check("R3 own selection high", int'(sel_neg), 1);
                check("R3 other selection low", int'(sel_pos), 0);
                check("R6 negative pulse", int'(drv_neg), e);
                check("R9 positive gate idle", int'(drv_pos), 0);
            end
            if (n == NHALF - H) begin
                mod_idx  = MW'(new_mod);
                dead_len = DW'(new_dead);
            end
            @(negedge clk);
        end
        g = 0;
        while (!sel_pos && !sel_neg && g < 100) begin
            check("R9 gates off in gap", int'(drv_pos || drv_neg), 0);
            if (g == 0) dead_len = DW'(gap_dead);
            g++;
            @(negedge clk);
        end
        check("R4 gap length", g, exp_gap);
        check("R4 polarity alternates", int'(neg ? sel_pos : sel_neg), 1);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        all_low("R1 in reset");
        rst = 1'b0;
        repeat (5) @(negedge clk);
        all_low("R1 enable low");

        // R2: start from idle
        mod_idx  = MW'(128);
        dead_len = DW'(3);
        en       = 1'b1;
        @(negedge clk);
        check("R2 not yet selected", int'(sel_pos), 0);
        @(negedge clk);
        check("R2 positive first", int'(sel_pos), 1);

        // R8 index 0.5; next index above limit clamps; dead 5 then ignored 12
        run_half(1'b0, 128, 255, 5, 12, 5);
        // R8 clamped index; next zero index and zero dead (acts as one)
        run_half(1'b1, clampm(255), 0, 0, 9, 1);
        // zero index: no pulses at all
        run_half(1'b0, 0, 64, 2, 2, 2);
        // R8 just above limit clamps
        run_half(1'b1, 64, 200, 3, 3, 3);
        check("R8 clamp of 200", clampm(200), LIMIT);

        // R10: disable in the middle of a half
        repeat (20) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        for (int c = 0; c < 20; c++) begin
            all_low("R10 disabled");
            @(negedge clk);
        end
        mod_idx = MW'(LIMIT);
        en      = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R10 restart positive", int'(sel_pos), 1);
        run_half(1'b0, LIMIT, LIMIT, 4, 4, 4);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule